// File: doc/BRIEF.md
# USB OTG Wrapper Interrupt Aggregator

This block sits beside a USB OTG controller core and gathers its side-band signals into one level interrupt for the host processor. Four OTG control outputs of the core are watched: drive-VBUS, charge-VBUS, discharge-VBUS and ID pull-up. Each is brought into the clock domain through a synchronizer. A latched event is raised on each rising edge and on each falling edge. Three more sources are sampled every clock and latched while high: a generic OTG event, a DMA-disable-cleared flag and the core's own interrupt.

Events are kept in two groups. The core group holds the core interrupt. The miscellaneous group holds the edge events and the two flags. Each group offers a raw view, a view masked by its enables, and a pair of enable registers for setting and clearing. Software reads the status, handles it, and writes the same value back to clear it. A 32-bit register port with a combinational read path gives access to all of this. A read-only revision word reports the register-map version.

Top module: `otgirq_wrap`

## Requirements
- R1: Input `otg_ctrl_in` has bit 0 = drive-VBUS, bit 1 = charge-VBUS, bit 2 = discharge-VBUS and bit 3 = ID pull-up. A rising edge on these sets miscellaneous status bit 13, 12, 11 and 8 respectively.
- R2: A falling edge on the same four lines (drive, charge, discharge, ID pull-up) sets miscellaneous status bit 5, 4, 3 and 0 respectively.
- R3: While `otg_evt_in` is high, miscellaneous bit 16 is set. While `dma_clr_in` is high, miscellaneous bit 17 is set. While `core_irq_in` is high, core-group bit 0 is set.
- R4: Register offsets (default map, `REV_MAJOR` = 1) are as follows. Revision is at 0x00. The core group has raw at 0x24, masked at 0x28, enable-set at 0x2C and enable-clear at 0x30. The miscellaneous group has raw at 0x38, masked at 0x3C, enable-set at 0x40 and enable-clear at 0x44. Revision reads `REV_MAJOR` in bits 10:8 and zero elsewhere. Unmapped offsets read zero. For `REV_MAJOR` above 2, the miscellaneous group moves up by 0x400.
- R5: Raw status shows every latched event whatever its enable. Masked status equals raw AND enable. Status and enable bits with no source always read zero.
- R6: Writing to a group's raw or masked offset clears each status bit written as one. Bits written as zero keep their value.
- R7: If an event occurs in the same cycle that a clear write targets its bit, the bit stays set.
- R8: Writing to enable-set sets the enables written as one. Writing to enable-clear clears them. Zero bits leave enables unchanged. Both enable offsets read back the current enables.
- R9: `irq_out` is the OR of all masked status bits of both groups. It falls once no masked bit remains, whether because the bits were cleared or because their enables were removed.
- R10: Reset clears all status and enables. The synchronizers load the current line levels, so lines held steady through reset raise no event.
- R11: With `SYNC_STAGES` = 2, a line change is first sampled at rising edge k. Its event bit is set at edge k+2 and is clear before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| otg_ctrl_in | input | 4 | OTG control lines from the core (asynchronous) |
| otg_evt_in | input | 1 | Generic OTG event (synchronous) |
| dma_clr_in | input | 1 | DMA-disable-cleared flag (synchronous) |
| core_irq_in | input | 1 | Controller core interrupt (synchronous) |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The bench sweeps every line in both directions. A swapped rise/fall table or a wrong line order shows up as an event landing on the wrong bit. It times the synchronizer to the exact cycle, so an extra or missing stage moves the event one cycle. It asserts reset with some lines already high: a detector that does not preload the line level would report a phantom edge. It walks a one-hot enable over all 32 bit positions against a full raw vector. It holds the core interrupt high across a clear write, which catches a clear that takes priority over the new event. It also checks that zero writes to the enable-set and status offsets change nothing.

// File: rtl/otgirq_pkg.sv
package otgirq_pkg;

    localparam int DATA_W     = 32;
    localparam int NUM_LINES  = 4;
    localparam int RISE_SHIFT = 8;
    localparam int BIT_OTGEVT = 16;
    localparam int BIT_DMACLR = 17;
    localparam int BIT_CORE   = 0;

    localparam logic [DATA_W-1:0] MISC_VALID = 32'h0003_3939;
    localparam logic [DATA_W-1:0] CORE_VALID = 32'h0000_0001;

    localparam logic [11:0] CORE_BASE   = 12'h024;
    localparam logic [11:0] MISC_COMPACT = 12'h038;
    localparam logic [11:0] MISC_MOVED   = 12'h438;
    localparam logic [11:0] REV_OFFSET  = 12'h000;

    typedef enum logic [2:0] {
        K_NONE,
        K_REV,
        K_RAW,
        K_MASKED,
        K_EN_SET,
        K_EN_CLR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        logic      misc;
    } reg_sel_t;

    typedef struct packed {
        logic [DATA_W-1:0] raw;
        logic [DATA_W-1:0] masked;
        logic [DATA_W-1:0] en;
        logic              pend;
    } grp_view_t;

    // falling-edge bit of a control line; its rising edge sits RISE_SHIFT above
    function automatic int fall_bit(input int line);
        case (line)
            0:       return 5;
            1:       return 4;
            2:       return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [11:0] misc_base(input int major);
        return (major <= 2) ? MISC_COMPACT : MISC_MOVED;
    endfunction

endpackage

// File: rtl/otgirq_edge.sv
module otgirq_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sq;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq   <= {STAGES{din}};
            prev <= din;
        end else begin
            sq[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                sq[i] <= sq[i-1];
            end
            prev <= sq[STAGES-1];
        end
    end

    assign rise = sq[STAGES-1] & ~prev;
    assign fall = ~sq[STAGES-1] & prev;

    initial begin
        assert (STAGES >= 2) else $error("STAGES below two");
    end
endmodule

// File: rtl/otgirq_group.sv
module otgirq_group
    import otgirq_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = 32'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              stat_clr_wr,
    input  logic              en_set_wr,
    input  logic              en_clr_wr,
    input  logic [DATA_W-1:0] wdata,
    output grp_view_t         view
);
    logic [DATA_W-1:0] raw_q, en_q, clr_mask, raw_d, en_d;

    always_comb begin
        clr_mask = stat_clr_wr ? wdata : '0;
        raw_d    = ((raw_q & ~clr_mask) | set_vec) & VALID;
        en_d     = en_q;
        if (en_set_wr) en_d = en_d | (wdata & VALID);
        if (en_clr_wr) en_d = en_d & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            en_q  <= '0;
        end else begin
            raw_q <= raw_d;
            en_q  <= en_d;
        end
    end

    assign view.raw    = raw_q;
    assign view.masked = raw_q & en_q;
    assign view.en     = en_q;
    assign view.pend   = |(raw_q & en_q);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (raw_q == '0 && en_q == '0));

    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        stat_clr_wr |=> ((raw_q & $past(wdata & ~set_vec)) == '0));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (|(set_vec & VALID)) |=> ((raw_q & $past(set_vec & VALID)) == $past(set_vec & VALID)));

    assert_en_set_R8: assert property (@(posedge clk) disable iff (rst)
        (en_set_wr && !en_clr_wr) |=>
            ((en_q & $past(wdata & VALID)) == $past(wdata & VALID)) &&
            ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));

    assert_en_clr_R8: assert property (@(posedge clk) disable iff (rst)
        en_clr_wr |=> ((en_q & $past(wdata)) == '0));
endmodule

// File: rtl/otgirq_wrap.sv
module otgirq_wrap
    import otgirq_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int REV_MAJOR   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [3:0]        otg_ctrl_in,
    input  logic              otg_evt_in,
    input  logic              dma_clr_in,
    input  logic              core_irq_in,
    output logic              irq_out
);
    localparam logic [11:0] MISC_BASE = misc_base(REV_MAJOR);
    localparam logic [2:0]  MAJOR_F   = 3'(REV_MAJOR);

    logic [NUM_LINES-1:0] rise, fall;
    logic [DATA_W-1:0]    misc_set, core_set;
    reg_sel_t             sel;
    grp_view_t            core_v, misc_v;
    logic [11:0]          a12;

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            otgirq_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk  (clk),
                .rst  (rst),
                .din  (otg_ctrl_in[g]),
                .rise (rise[g]),
                .fall (fall[g])
            );
        end
    endgenerate

    always_comb begin
        misc_set = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            misc_set[fall_bit(i)]              = fall[i];
            misc_set[fall_bit(i) + RISE_SHIFT] = rise[i];
        end
        misc_set[BIT_OTGEVT] = otg_evt_in;
        misc_set[BIT_DMACLR] = dma_clr_in;
        core_set             = '0;
        core_set[BIT_CORE]   = core_irq_in;
    end

    always_comb begin
        a12      = 12'(reg_addr);
        sel.kind = K_NONE;
        sel.misc = 1'b0;
        if (a12 == REV_OFFSET)               sel.kind = K_REV;
        else if (a12 == CORE_BASE)           sel.kind = K_RAW;
        else if (a12 == CORE_BASE + 12'h4)   sel.kind = K_MASKED;
        else if (a12 == CORE_BASE + 12'h8)   sel.kind = K_EN_SET;
        else if (a12 == CORE_BASE + 12'hC)   sel.kind = K_EN_CLR;
        else begin
            sel.misc = 1'b1;
            if (a12 == MISC_BASE)              sel.kind = K_RAW;
            else if (a12 == MISC_BASE + 12'h4) sel.kind = K_MASKED;
            else if (a12 == MISC_BASE + 12'h8) sel.kind = K_EN_SET;
            else if (a12 == MISC_BASE + 12'hC) sel.kind = K_EN_CLR;
            else                                sel.misc = 1'b0;
        end
    end

    logic stat_wr, enset_wr, enclr_wr;
    assign stat_wr  = reg_wr && (sel.kind == K_RAW || sel.kind == K_MASKED);
    assign enset_wr = reg_wr && (sel.kind == K_EN_SET);
    assign enclr_wr = reg_wr && (sel.kind == K_EN_CLR);

    otgirq_group #(.VALID(CORE_VALID)) u_core (
        .clk         (clk),
        .rst         (rst),
        .set_vec     (core_set),
        .stat_clr_wr (stat_wr && !sel.misc),
        .en_set_wr   (enset_wr && !sel.misc),
        .en_clr_wr   (enclr_wr && !sel.misc),
        .wdata       (reg_wdata),
        .view        (core_v)
    );

    otgirq_group #(.VALID(MISC_VALID)) u_misc (
        .clk         (clk),
        .rst         (rst),
        .set_vec     (misc_set),
        .stat_clr_wr (stat_wr && sel.misc),
        .en_set_wr   (enset_wr && sel.misc),
        .en_clr_wr   (enclr_wr && sel.misc),
        .wdata       (reg_wdata),
        .view        (misc_v)
    );

    grp_view_t pick;
    assign pick = sel.misc ? misc_v : core_v;

    always_comb begin
        case (sel.kind)
            K_REV:              reg_rdata = {21'b0, MAJOR_F, 8'b0};
            K_RAW:              reg_rdata = pick.raw;
            K_MASKED:           reg_rdata = pick.masked;
            K_EN_SET, K_EN_CLR: reg_rdata = pick.en;
            default:            reg_rdata = '0;
        endcase
    end

    assign irq_out = core_v.pend | misc_v.pend;

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (core_v.masked == '0 && misc_v.masked == '0) |-> !irq_out);
endmodule

// File: tb/otgirq_wrap_test.sv
module otgirq_wrap_test;
    localparam logic [31:0] MVALID = 32'h0003_3939;
    localparam logic [11:0] C_RAW = 12'h024, C_MSK = 12'h028, C_SET = 12'h02C, C_CLR = 12'h030;
    localparam logic [11:0] M_RAW = 12'h038, M_MSK = 12'h03C, M_SET = 12'h040, M_CLR = 12'h044;

    logic        clk = 0;
    logic        rst = 1;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  otg_ctrl_in = 4'b1010;
    logic        otg_evt_in = 0, dma_clr_in = 0, core_irq_in = 0;
    logic        irq_out;

    int tests = 0, fails = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    otgirq_wrap uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .otg_ctrl_in(otg_ctrl_in),
        .otg_evt_in(otg_evt_in), .dma_clr_in(dma_clr_in), .core_irq_in(core_irq_in),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int fbit(input int line);
        return (line == 3) ? 0 : 5 - line;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [3:0]  lv;
        repeat (4) @(negedge clk);
        rst = 0;
        cyc(5);
        // R10: lines 1 and 3 high through reset, no phantom edges
        rd(M_RAW, v); check("R10 misc raw after reset", v, 0);
        rd(C_RAW, v); check("R10 core raw after reset", v, 0);
        rd(M_SET, v); check("R10 misc enables after reset", v, 0);
        check("R10 irq after reset", {31'b0, irq_out}, 0);
        // R4 revision and unmapped
        rd(12'h000, v); check("R4 revision", v, 32'h100);
        rd(12'h004, v); check("R4 unmapped", v, 0);
        rd(12'h034, v); check("R4 unmapped gap", v, 0);

        // R11 exact timing: line 0 low -> high
        @(negedge clk); otg_ctrl_in[0] = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_addr = M_RAW; #1;
        check("R11 not before edge k+2", reg_rdata, 0);
        @(posedge clk); @(negedge clk); #1;
        check("R11 set at edge k+2", reg_rdata, 32'h1 << 13);
        wr(M_RAW, 32'hFFFF_FFFF);
        rd(M_RAW, v); check("R6 clear all", v, 0);

        // R1 / R2 sweep over every line, both directions
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < 2; k++) begin
                lv = otg_ctrl_in;
                @(negedge clk); otg_ctrl_in[i] = ~lv[i];
                cyc(4);
                rd(M_RAW, v);
                if (lv[i]) check($sformatf("R2 fall line %0d", i), v, 32'h1 << fbit(i));
                else       check($sformatf("R1 rise line %0d", i), v, 32'h1 << (fbit(i) + 8));
                wr(M_RAW, v);
                rd(M_RAW, v); check("R6 write-back clears", v, 0);
            end
        end

        // R3 flags
        @(negedge clk); otg_evt_in = 1; @(negedge clk); otg_evt_in = 0;
        @(negedge clk); dma_clr_in = 1; @(negedge clk); dma_clr_in = 0;
        @(negedge clk); core_irq_in = 1; @(negedge clk); core_irq_in = 0;
        rd(M_RAW, v); check("R3 otg evt and dma clr bits", v, 32'h0003_0000);
        rd(C_RAW, v); check("R3 core bit", v, 32'h1);
        // R5 disabled: raw visible, masked zero, no irq
        rd(C_MSK, v); check("R5 core masked with enable off", v, 0);
        check("R9 no irq when disabled", {31'b0, irq_out}, 0);
        // R6 zeros leave status
        wr(M_RAW, 32'h0);
        rd(M_RAW, v); check("R6 zero write keeps status", v, 32'h0003_0000);
        wr(M_MSK, 32'h0001_0000);
        rd(M_RAW, v); check("R6 clear through masked view", v, 32'h0002_0000);

        // R8 enables
        wr(M_SET, 32'hFFFF_FFFF);
        rd(M_SET, v); check("R8 set all reads valid bits", v, MVALID);
        wr(M_SET, 32'h0);
        rd(M_CLR, v); check("R8 zero set keeps enables", v, MVALID);
        wr(M_CLR, 32'h0);
        rd(M_SET, v); check("R8 zero clear keeps enables", v, MVALID);
        wr(M_CLR, 32'h0000_3900);
        rd(M_CLR, v); check("R8 partial clear", v, MVALID & ~32'h3900);
        check("R9 irq from misc bit 17", {31'b0, irq_out}, 1);
        wr(M_RAW, 32'h0002_0000);
        check("R9 irq drops after clear", {31'b0, irq_out}, 0);
        wr(M_CLR, 32'hFFFF_FFFF);

        // build full raw vector
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); otg_ctrl_in[i] = ~otg_ctrl_in[i]; cyc(4);
            @(negedge clk); otg_ctrl_in[i] = ~otg_ctrl_in[i]; cyc(4);
        end
        @(negedge clk); otg_evt_in = 1; dma_clr_in = 1;
        @(negedge clk); otg_evt_in = 0; dma_clr_in = 0;
        rd(M_RAW, v); check("R1 R2 R3 all events latched", v, MVALID);
        // R5 / R9 one-hot enable sweep
        for (int b = 0; b < 32; b++) begin
            wr(M_CLR, 32'hFFFF_FFFF);
            wr(M_SET, 32'h1 << b);
            rd(M_MSK, v);
            check($sformatf("R5 masked bit %0d", b), v, MVALID & (32'h1 << b));
            check($sformatf("R9 irq bit %0d", b), {31'b0, irq_out}, {31'b0, MVALID[b]});
        end
        wr(M_CLR, 32'hFFFF_FFFF);
        check("R9 irq drops when enables removed", {31'b0, irq_out}, 0);
        wr(M_RAW, 32'hFFFF_FFFF);

        // R7 event beats concurrent clear; core group enables
        wr(C_SET, 32'hFFFF_FFFF);
        rd(C_CLR, v); check("R8 core enable reads valid bit", v, 32'h1);
        @(negedge clk); core_irq_in = 1;
        wr(C_RAW, 32'h1);
        rd(C_RAW, v); check("R7 set wins over clear", v, 32'h1);
        check("R9 irq from core", {31'b0, irq_out}, 1);
        @(negedge clk); core_irq_in = 0;
        wr(C_MSK, 32'h1);
        rd(C_RAW, v); check("R6 core cleared", v, 0);
        check("R9 irq low at end", {31'b0, irq_out}, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule